// File: doc/BRIEF.md
# Sequential Unsigned Integer Divider

This block divides one unsigned WIDTH-bit integer by another. It works one quotient bit per clock, so a division takes WIDTH iteration cycles plus one closing cycle. It keeps a partial remainder that is one bit wider than the operands, a shifting register that starts out holding the dividend and fills up with quotient bits, and a copy of the divisor.

In the default method, each iteration chooses between adding and subtracting the divisor from the sign of the partial remainder. The closing cycle adds the divisor back once if the remainder ended negative. A per-operation mode input selects the other method instead. That method always tries a subtraction and keeps the old partial remainder when the trial goes negative. Both methods give the same results.

A caller raises `start_i` for one cycle while the block is idle. It then waits for the one-cycle `done_o` pulse and reads the quotient and remainder, which stay put until the next operation completes. A zero divisor skips the iterations and is reported through a flag.

Top module: `nonrest_divider`

## Requirements
- R1: While reset is asserted and after its release, busy_o, done_o and div_zero_o are 0, and quotient_o and remainder_o are 0.
- R2: A start_i seen at a clock edge while busy_o is 0 raises busy_o after that edge. For a non-zero divisor, done_o rises after the WIDTH+1-th following edge, and busy_o falls at the same edge.
- R3: A start_i seen while busy_o is 1 is ignored. The operation in flight completes with its original operands.
- R4: With mode_i = 0 (add-or-subtract chosen by sign, with one final correction), quotient_o equals floor(dividend/divisor) and remainder_o equals dividend mod divisor, for a non-zero divisor.
- R5: With mode_i = 1 (trial subtraction with restore), the results are the same as in R4.
- R6: Corner cases give exact results: divisor 1 gives quotient = dividend and remainder 0, a divisor larger than the dividend gives quotient 0 and remainder = dividend, and 11 divided by 3 gives quotient 3 and remainder 2.
- R7: A zero divisor sets div_zero_o together with done_o, one edge after the start edge. In that case quotient_o is all ones and remainder_o equals the dividend. div_zero_o is 0 for any other completion.
- R8: done_o is high for exactly one cycle and never while busy_o is high. quotient_o, remainder_o and div_zero_o change only at the edge that raises done_o.
- R9: A start_i given during the cycle in which done_o is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division (taken only while idle) |
| mode_i | input | 1 | 0: sign-steered add/subtract, 1: trial subtraction with restore |
| dividend_i | input | WIDTH | Unsigned dividend, sampled at start |
| divisor_i | input | WIDTH | Unsigned divisor, sampled at start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last completed operation had a zero divisor |
| quotient_o | output | WIDTH | Quotient of the last completed operation |
| remainder_o | output | WIDTH | Remainder of the last completed operation |

## Verification
Two events can fall in the same cycle: the completion pulse of one division and the acceptance of the next start. The bench provokes this by driving the next start_i in the very cycle where done_o is observed high. In the same way, a start pulse with different operands is placed in the middle of a running division. A behavioural model built from integer division and a countdown predicts busy_o, done_o, the flag and both results on every clock. Any slip in acceptance, latency or held results is therefore reported at the cycle where it happens.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

  typedef enum logic {
    MODE_NONREST = 1'b0,
    MODE_REST    = 1'b1
  } div_mode_e;
endpackage

// File: rtl/div_step.sv
module div_step
  import div_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  div_mode_e    mode_i,
  input  logic [W:0]   acc_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] m_i,
  output logic [W:0]   acc_o,
  output logic [W-1:0] q_o
);
  logic [W:0] shifted, mx, sum, dif;
  logic       qbit;

  always_comb begin
    // acc:q shifted left as one unit; the dropped top bit is covered by wraparound
    shifted = {acc_i[W-1:0], q_i[W-1]};
    mx      = {1'b0, m_i};
    sum     = shifted + mx;
    dif     = shifted - mx;
    if (mode_i == MODE_REST) begin
      acc_o = dif[W] ? shifted : dif;
      qbit  = ~dif[W];
    end else begin
      acc_o = acc_i[W] ? sum : dif;
      qbit  = ~acc_o[W];
    end
    q_o = {q_i[W-2:0], qbit};
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic zero_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(W + 1);

  div_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign step_o   = (state_q == ST_ITER);
  assign finish_o = (state_q == ST_FIX);
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= zero_i ? ST_FIX : ST_ITER;
          cnt_q   <= CW'(W);
        end
        ST_ITER: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nonrest_divider.sv
module nonrest_divider
  import div_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             div_zero_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);
  localparam int unsigned W = WIDTH;

  logic         load, step, finish;
  logic [W:0]   acc_q, acc_nx, acc_fix;
  logic [W-1:0] q_q, q_nx, m_q;
  div_mode_e    mode_q;
  logic         zero_q;
  logic         done_q, dz_q;
  logic [W-1:0] quo_q, rem_q;

  div_ctrl #(.W(W)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .zero_i  (divisor_i == '0),
    .load_o  (load),
    .step_o  (step),
    .finish_o(finish),
    .busy_o  (busy_o)
  );

  div_step #(.W(W)) step_i (
    .mode_i(mode_q),
    .acc_i (acc_q),
    .q_i   (q_q),
    .m_i   (m_q),
    .acc_o (acc_nx),
    .q_o   (q_nx)
  );

  // single closing correction for a negative partial remainder
  assign acc_fix = acc_q + {1'b0, m_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      q_q    <= '0;
      m_q    <= '0;
      mode_q <= MODE_NONREST;
      zero_q <= 1'b0;
    end else if (load) begin
      acc_q  <= '0;
      q_q    <= dividend_i;
      m_q    <= divisor_i;
      mode_q <= div_mode_e'(mode_i);
      zero_q <= (divisor_i == '0);
    end else if (step) begin
      acc_q <= acc_nx;
      q_q   <= q_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      dz_q   <= 1'b0;
      quo_q  <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= finish;
      if (finish) begin
        dz_q <= zero_q;
        if (zero_q) begin
          quo_q <= '1;
          rem_q <= q_q;
        end else begin
          quo_q <= q_q;
          rem_q <= acc_q[W] ? acc_fix[W-1:0] : acc_q[W-1:0];
        end
      end
    end
  end

  assign done_o      = done_q;
  assign div_zero_o  = dz_q;
  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
endmodule

// File: rtl/nonrest_divider_chk.sv
module nonrest_divider_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             mode_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             div_zero_o,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o
);
  localparam int unsigned LW = $clog2(WIDTH + 3);

  logic [WIDTH-1:0] dvd_c, dvs_c;
  logic [LW-1:0]    lat_q;
  logic [2*WIDTH:0] recon;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_c <= '0;
      dvs_c <= '0;
      lat_q <= '0;
    end else if (start_i && !busy_o) begin
      dvd_c <= dividend_i;
      dvs_c <= divisor_i;
      lat_q <= '0;
    end else if (busy_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  assign recon = quotient_o * dvs_c + remainder_o;

  p_done_not_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));
  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == ((dvs_c == '0) ? LW'(1) : LW'(WIDTH + 1))));
  p_result_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_zero_o) |-> (recon == {{(WIDTH+1){1'b0}}, dvd_c} && remainder_o < dvs_c));
  p_zero_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (div_zero_o == (dvs_c == '0)));
  p_zero_result_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_zero_o) |-> (quotient_o == '1 && remainder_o == dvd_c));
endmodule

bind nonrest_divider nonrest_divider_chk #(.WIDTH(WIDTH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .div_zero_o (div_zero_o),
  .quotient_o (quotient_o),
  .remainder_o(remainder_o)
);

// File: tb/nonrest_divider_tb_top.sv
module nonrest_divider_tb_top;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int MAX_CYCLES = 100000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         busy_o, done_o, div_zero_o;
  logic [W-1:0] quotient_o, remainder_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nonrest_divider #(.WIDTH(W)) dut_i (
    .clk_i, .rst_ni, .start_i, .mode_i, .dividend_i, .divisor_i,
    .busy_o, .done_o, .div_zero_o, .quotient_o, .remainder_o
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // behavioural reference model
  bit     m_busy = 0, m_done = 0, m_dz = 0;
  int     m_left = 0;
  longint m_q = 0, m_r = 0, p_q = 0, p_r = 0;
  bit     p_dz = 0, p_mode = 0, m_mode = 0;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > MAX_CYCLES) begin
      chk(0, "watchdog", cyc, MAX_CYCLES);
      finish_run();
    end
    if (rst_ni) begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r; m_dz = p_dz; m_mode = p_mode;
        end
      end else if (start_i) begin
        m_busy = 1;
        p_mode = mode_i;
        if (divisor_i == 0) begin
          p_dz = 1; p_q = (1 << W) - 1; p_r = dividend_i; m_left = 1;
        end else begin
          p_dz = 0; p_q = dividend_i / divisor_i; p_r = dividend_i % divisor_i; m_left = W + 1;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(busy_o == m_busy, "R2 busy", busy_o, m_busy);
      chk(done_o == m_done, "R8 done", done_o, m_done);
      chk(div_zero_o == m_dz, "R7 flag", div_zero_o, m_dz);
      chk(quotient_o == W'(m_q), m_mode ? "R5 quotient" : "R4 quotient", quotient_o, m_q);
      chk(remainder_o == W'(m_r), m_mode ? "R5 remainder" : "R4 remainder", remainder_o, m_r);
    end
  end

  task automatic issue(input int dvd, input int dvs, input bit md);
    while (busy_o) @(negedge clk_i);
    start_i = 1; dividend_i = W'(dvd); divisor_i = W'(dvs); mode_i = md;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic run(input int dvd, input int dvs, input bit md);
    issue(dvd, dvs, md);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !div_zero_o, "R1 flags", {busy_o, done_o, div_zero_o}, 0);
    chk(quotient_o == 0 && remainder_o == 0, "R1 results", {quotient_o, remainder_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && quotient_o == 0, "R1 after release", quotient_o, 0);

    for (int md = 0; md < 2; md++) begin
      run(11, 3, md[0]);
      chk(quotient_o == 3 && remainder_o == 2, "R6 11/3", {quotient_o, remainder_o}, {8'd3, 8'd2});
      run(200, 1, md[0]);
      chk(quotient_o == 200 && remainder_o == 0, "R6 div1", quotient_o, 200);
      run(17, 250, md[0]);
      chk(quotient_o == 0 && remainder_o == 17, "R6 big divisor", remainder_o, 17);
      run(255, 255, md[0]);
      chk(quotient_o == 1 && remainder_o == 0, "R6 equal", quotient_o, 1);
      run(93, 0, md[0]);
      chk(div_zero_o && quotient_o == 8'hff && remainder_o == 93, "R7 zero divisor",
          remainder_o, 93);
    end

    // R3: start during a running division is ignored
    issue(100, 7, 0);
    @(negedge clk_i);
    start_i = 1; dividend_i = 50; divisor_i = 3;
    @(negedge clk_i);
    start_i = 0;
    wait_done();
    chk(quotient_o == 14 && remainder_o == 2, "R3 ignored start", quotient_o, 14);

    // R9: next start in the done cycle
    issue(77, 5, 1);
    wait_done();
    issue(250, 9, 0);
    chk(busy_o == 1, "R9 back-to-back accept", busy_o, 1);
    wait_done();
    chk(quotient_o == 27 && remainder_o == 7, "R9 result", quotient_o, 27);

    for (int i = 0; i < 300; i++) begin
      int a, b;
      a = int'($urandom_range(0, 255));
      b = (i % 10 == 0) ? int'($urandom_range(a, 255)) : int'($urandom_range(1, 255));
      run(a, b, i[0]);
      chk(quotient_o == W'(a / b) && remainder_o == W'(a % b),
          i[0] ? "R5 random" : "R4 random", {quotient_o, remainder_o}, {W'(a / b), W'(a % b)});
    end

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule